// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block holds the register set behind a 256-position digital potentiometer and decides how each byte arriving from a two-wire serial slave front end is answered. The front end reports bus events as single-cycle strobes: a start (with the read/write bit), a stop, a received byte, and a request for a byte to transmit. The block returns an acknowledge decision for every received byte, supplies read data, and raises a busy flag that tells the front end to stop acknowledging its slave address.

Address 0 is a window onto either the volatile wiper register or the non-volatile initial-value register, chosen by bit 7 of a control register at address 8. Addresses 2 to 6 are general-purpose non-volatile bytes and address 1 is a fixed identification byte. Non-volatile writes are staged and committed only by a stop that immediately follows the data byte, after which a timer emulates the programming cycle. After reset the wiper sits at midscale while a power-up delay runs, then takes the initial-value register. Non-volatile contents are cleared to factory defaults only by the power-on reset input and survive the soft reset.

Top module: `potw_regfile`

## Requirements
- R1: During soft reset and for PU_CYCLES+1 cycles after it, busy is 1 and the wiper code is 80h; in the cycle busy falls the wiper code takes the initial-value register.
- R2: The first byte after a write-mode start is the register address: 00h–06h and 08h are acknowledged; 07h or any value above 08h is refused, and every later byte of that transfer is refused.
- R3: A data byte to address 8 loads its bit 7 into the view-select bit and is acknowledged only when it is 00h or 80h; the view-select bit is 0 after soft reset; reading address 8 returns the bit in position 7 with all other bits 0.
- R4: With the view-select bit 0, a data byte to address 0 goes to the wiper and, after commit, the initial-value register, and reading address 0 returns the initial-value register; with the bit 1, the write goes to the wiper only and a read returns the wiper register.
- R5: The wiper code equals an accepted address-0 data byte in the cycle after that byte, without waiting for any commit.
- R6: Address 1 reads D0h; a data byte written to it is acknowledged and changes nothing.
- R7: Addresses 2–6 read 00h after power-on reset, hold committed values, and like the initial-value register keep them through a soft reset.
- R8: While write-protect (active low) is 0, data bytes for non-volatile registers are refused and nothing changes; a stop while it is 0 drops a staged write; it has no effect once a commit has begun.
- R9: A further data byte is accepted only after a byte to address 8 (the address then moves to 0); after any other data byte, later bytes are refused and a staged write is dropped.
- R10: A staged non-volatile write is committed only by a stop directly after its data byte; a repeated start drops it.
- R11: A commit holds busy for NV_CYCLES cycles; while busy is 1, all bus events are ignored, with no acknowledge decision and no read data.
- R12: Each read returns the register at the current address and advances it; 07h reads FFh, 08h is followed by 00h; a read started without an address continues from the last accessed address plus one.
- R13: The tap select output has exactly one bit set, at the index equal to the wiper code (bit 0 is the low end, bit 255 the high end).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low soft reset (volatile state, power-up sequence) |
| por_n | input | 1 | Synchronous active-low power-on reset for non-volatile contents |
| wp_n | input | 1 | Write protect, active low |
| evt_start | input | 1 | Start or repeated start with matching slave address |
| evt_rw | input | 1 | Read/write bit qualifying evt_start (1 = read) |
| evt_stop | input | 1 | Stop condition |
| evt_wbyte | input | 1 | A byte was received from the master |
| wbyte_data | input | 8 | Received byte, valid with evt_wbyte |
| evt_rbyte | input | 1 | Front end needs the next byte to transmit |
| ack_vld | output | 1 | Acknowledge decision valid (cycle after evt_wbyte) |
| ack_ok | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_vld | output | 1 | Read data valid (cycle after evt_rbyte) |
| rd_data | output | 8 | Byte to transmit |
| busy | output | 1 | Power-up or commit in progress; do not acknowledge the slave address |
| wiper_pos | output | 8 | Wiper code |
| tap_sel | output | 256 | One-hot tap select |

## Verification
The assertions assume that at most one bus strobe is high in any cycle, that evt_rw is meaningful only with evt_start, and that the front end honours busy; the property that events during busy are ignored is still exercised by deliberately sending them. The stimulus drives exactly one strobe per task, one cycle wide, between clock edges, and toggles write-protect only between events. A behavioural model in the bench predicts every acknowledge, read byte, the busy window and the wiper code, and these are compared on every clock.

// File: rtl/potw_pkg.sv
// Shared constants and types for the potentiometer register controller.
// Assumes an 8-bit register data path and a 4-bit register pointer.
package potw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,   // no write transfer open (or read mode)
        PH_ADDR,   // next received byte is the register address
        PH_DATA,   // next received byte is data for ptr
        PH_HALT    // transfer closed: further bytes refused
    } potw_phase_e;

    localparam logic [3:0] ADDR_VIEW0 = 4'd0;
    localparam logic [3:0] ADDR_IDENT = 4'd1;
    localparam logic [3:0] ADDR_GP_LO = 4'd2;
    localparam logic [3:0] ADDR_HOLE  = 4'd7;
    localparam logic [3:0] ADDR_CTRL  = 4'd8;
    localparam int         GP_COUNT   = 5;

    localparam logic [7:0] IDENT_BYTE = 8'hD0;
    localparam logic [7:0] MIDSCALE   = 8'h80;
    localparam logic [7:0] HOLE_BYTE  = 8'hFF;

    // Pointer advance: wraps from the control register back to address 0.
    function automatic logic [3:0] ptr_step(input logic [3:0] p);
        return (p == ADDR_CTRL) ? ADDR_VIEW0 : p + 4'd1;
    endfunction

endpackage

// File: rtl/potw_busy_timer.sv
// Busy timer: runs the power-up delay after soft reset, then counts the
// emulated non-volatile programming cycle after each commit.
// Assumes commit_i never arrives while busy_o is high.
module potw_busy_timer #(
    parameter int NV_CYCLES = 400000,
    parameter int PU_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit_i,
    output logic busy_o,
    output logic pu_load_o
);
    localparam int CNT_MAX = (NV_CYCLES > PU_CYCLES) ? NV_CYCLES : PU_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pu_q;

    // Count down the active window; the power-up window ends with a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(PU_CYCLES);
            pu_q  <= 1'b1;
        end else begin
            if (commit_i)
                cnt_q <= CNT_W'(NV_CYCLES);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            if (pu_q && cnt_q == '0)
                pu_q <= 1'b0;
        end
    end

    assign busy_o    = pu_q || (cnt_q != '0);
    assign pu_load_o = pu_q && (cnt_q == '0);

    // R11
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> busy_o);

    // R1
    pu_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pu_load_o |=> !busy_o);

endmodule

// File: rtl/potw_read_mux.sv
// Read data selection for the current register pointer.
// Assumes gp_i[0] is address 2 and pointers above 8 never occur.
module potw_read_mux
    import potw_pkg::*;
(
    input  logic [3:0]          addr_i,
    input  logic                view_vol_i,
    input  logic [7:0]          wiper_i,
    input  logic [7:0]          init_i,
    input  logic [GP_COUNT-1:0][7:0] gp_i,
    output logic [7:0]          data_o
);
    // Decode the pointer into the byte to transmit.
    always_comb begin
        data_o = 8'h00;
        if (addr_i == ADDR_VIEW0)
            data_o = view_vol_i ? wiper_i : init_i;
        else if (addr_i == ADDR_IDENT)
            data_o = IDENT_BYTE;
        else if (addr_i == ADDR_HOLE)
            data_o = HOLE_BYTE;
        else if (addr_i == ADDR_CTRL)
            data_o = {view_vol_i, 7'b0};
        else
            for (int i = 0; i < GP_COUNT; i++)
                if (addr_i == ADDR_GP_LO + 4'(i))
                    data_o = gp_i[i];
    end

endmodule

// File: rtl/potw_tap_decode.sv
// One-hot tap decoder: bit N is set when the wiper code equals N.
// Assumes TAPS is a power of two.
module potw_tap_decode #(
    parameter int TAPS  = 256,
    localparam int POS_W = $clog2(TAPS)
) (
    input  logic [POS_W-1:0] pos_i,
    output logic [TAPS-1:0]  sel_o
);
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign sel_o[t] = (pos_i == POS_W'(t));
    end

endmodule

// File: rtl/potw_regfile.sv
// Register controller for a digital potentiometer behind a serial slave
// front end. Decodes byte strobes into address and data phases, answers
// each byte with an acknowledge decision, stages and commits non-volatile
// writes, and drives the wiper code and one-hot tap select.
// Assumes at most one strobe per cycle and that evt_rw qualifies evt_start.
module potw_regfile
    import potw_pkg::*;
#(
    parameter int TAPS      = 256,
    parameter int NV_CYCLES = 400000,
    parameter int PU_CYCLES = 1000,
    localparam int POS_W    = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             wp_n,
    input  logic             evt_start,
    input  logic             evt_rw,
    input  logic             evt_stop,
    input  logic             evt_wbyte,
    input  logic [7:0]       wbyte_data,
    input  logic             evt_rbyte,
    output logic             ack_vld,
    output logic             ack_ok,
    output logic             rd_vld,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic [POS_W-1:0] wiper_pos,
    output logic [TAPS-1:0]  tap_sel
);
    potw_phase_e               ph_q;
    logic [3:0]                ptr_q;
    logic                      view_vol_q;
    logic [7:0]                wr_q;
    logic [7:0]                ivr_q;
    logic [GP_COUNT-1:0][7:0]  gp_q;
    logic                      pend_q;
    logic [3:0]                pend_addr_q;
    logic [7:0]                pend_data_q;
    logic                      ack_vld_q, ack_ok_q, rd_vld_q;
    logic [7:0]                rd_data_q;
    logic [7:0]                rd_mux;
    logic                      pu_load, commit_go, addr_legal;
    logic                      go_start, go_stop, go_wbyte, go_rbyte;

    // Bus events are ignored while the timer reports busy.
    assign go_start  = evt_start && !busy;
    assign go_stop   = evt_stop  && !busy;
    assign go_wbyte  = evt_wbyte && !busy;
    assign go_rbyte  = evt_rbyte && !busy;
    assign addr_legal = (wbyte_data <= 8'd8) && (wbyte_data != 8'd7);
    assign commit_go = go_stop && pend_q && wp_n;

    potw_busy_timer #(.NV_CYCLES(NV_CYCLES), .PU_CYCLES(PU_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit_go),
        .busy_o    (busy),
        .pu_load_o (pu_load)
    );

    potw_read_mux u_rmux (
        .addr_i     (ptr_q),
        .view_vol_i (view_vol_q),
        .wiper_i    (wr_q),
        .init_i     (ivr_q),
        .gp_i       (gp_q),
        .data_o     (rd_mux)
    );

    potw_tap_decode #(.TAPS(TAPS)) u_taps (
        .pos_i (wiper_pos),
        .sel_o (tap_sel)
    );

    // Transfer sequencing, volatile registers and answer generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q        <= PH_IDLE;
            ptr_q       <= ADDR_VIEW0;
            view_vol_q  <= 1'b0;
            wr_q        <= MIDSCALE;
            pend_q      <= 1'b0;
            pend_addr_q <= ADDR_VIEW0;
            pend_data_q <= 8'h00;
            ack_vld_q   <= 1'b0;
            ack_ok_q    <= 1'b0;
            rd_vld_q    <= 1'b0;
            rd_data_q   <= 8'h00;
        end else begin
            ack_vld_q <= 1'b0;
            rd_vld_q  <= 1'b0;
            if (pu_load)
                wr_q <= ivr_q;
            if (go_start) begin
                ph_q   <= evt_rw ? PH_IDLE : PH_ADDR;
                pend_q <= 1'b0;
            end else if (go_stop) begin
                ph_q   <= PH_IDLE;
                pend_q <= 1'b0;
            end else if (go_rbyte) begin
                rd_vld_q  <= 1'b1;
                rd_data_q <= rd_mux;
                ptr_q     <= ptr_step(ptr_q);
            end else if (go_wbyte) begin
                ack_vld_q <= 1'b1;
                ack_ok_q  <= 1'b0;
                pend_q    <= 1'b0;
                case (ph_q)
                    PH_ADDR: begin
                        if (addr_legal) begin
                            ptr_q    <= wbyte_data[3:0];
                            ph_q     <= PH_DATA;
                            ack_ok_q <= 1'b1;
                        end else begin
                            ph_q <= PH_HALT;
                        end
                    end
                    PH_DATA: begin
                        ptr_q <= ptr_step(ptr_q);
                        ph_q  <= PH_HALT;
                        if (ptr_q == ADDR_CTRL) begin
                            view_vol_q <= wbyte_data[7];
                            ack_ok_q   <= (wbyte_data[6:0] == 7'd0);
                            ph_q       <= PH_DATA;
                        end else if (ptr_q == ADDR_IDENT) begin
                            ack_ok_q <= 1'b1;
                        end else if (ptr_q == ADDR_VIEW0 && view_vol_q) begin
                            wr_q     <= wbyte_data;
                            ack_ok_q <= 1'b1;
                        end else if (wp_n) begin
                            ack_ok_q    <= 1'b1;
                            pend_q      <= 1'b1;
                            pend_addr_q <= ptr_q;
                            pend_data_q <= wbyte_data;
                            if (ptr_q == ADDR_VIEW0)
                                wr_q <= wbyte_data;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Non-volatile contents: factory defaults on power-on, written on commit.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ivr_q <= MIDSCALE;
            gp_q  <= '0;
        end else if (commit_go) begin
            if (pend_addr_q == ADDR_VIEW0)
                ivr_q <= pend_data_q;
            for (int i = 0; i < GP_COUNT; i++)
                if (pend_addr_q == ADDR_GP_LO + 4'(i))
                    gp_q[i] <= pend_data_q;
        end
    end

    assign ack_vld   = ack_vld_q;
    assign ack_ok    = ack_ok_q;
    assign rd_vld    = rd_vld_q;
    assign rd_data   = rd_data_q;
    assign wiper_pos = wr_q[7 -: POS_W];

    // R3
    ctrl_value_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wbyte && ph_q == PH_DATA && ptr_q == ADDR_CTRL)
        |=> (ack_ok_q == ($past(wbyte_data[6:0]) == 7'd0)));

    // R5
    wiper_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wbyte && ph_q == PH_DATA && ptr_q == ADDR_VIEW0 && (view_vol_q || wp_n))
        |=> (wr_q == $past(wbyte_data)));

    // R8
    protect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !wp_n |=> ($stable(ivr_q) && $stable(gp_q)));

    // R11
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!ack_vld && !rd_vld));

    // R13
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

endmodule

// File: tb/sim_potw_regfile.sv
`timescale 1ns/1ps
// Bench: behavioural model of the register controller, compared every clock.
module sim_potw_regfile;
    localparam int NV = 20;
    localparam int PU = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, por_n = 1'b0, wp_n = 1'b1;
    logic evt_start = 1'b0, evt_rw = 1'b0, evt_stop = 1'b0;
    logic evt_wbyte = 1'b0, evt_rbyte = 1'b0;
    logic [7:0] wbyte_data = 8'h00;
    logic ack_vld, ack_ok, rd_vld, busy;
    logic [7:0] rd_data, wiper_pos;
    logic [255:0] tap_sel;

    potw_regfile #(.TAPS(256), .NV_CYCLES(NV), .PU_CYCLES(PU)) u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wp_n(wp_n),
        .evt_start(evt_start), .evt_rw(evt_rw), .evt_stop(evt_stop),
        .evt_wbyte(evt_wbyte), .wbyte_data(wbyte_data), .evt_rbyte(evt_rbyte),
        .ack_vld(ack_vld), .ack_ok(ack_ok), .rd_vld(rd_vld), .rd_data(rd_data),
        .busy(busy), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
    );

    always #4 clk = ~clk;

    int nchk = 0, nfail = 0;
    bit chk_en = 0, done = 0, was_busy = 0;
    // model state
    int m_wr, m_ivr, m_view, m_ptr, m_mode, m_pend, m_paddr, m_pdata, m_busy, m_pu;
    int m_gp[2:6];

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison of busy, wiper code and tap select.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check("R11 busy", int'(busy), int'(m_busy > 0));
            check("R1 wiper", int'(wiper_pos), m_wr);
            check("R13 taps", $countones(tap_sel), 1);
            check("R13 tapbit", int'(tap_sel[m_wr[7:0]]), 1);
        end
    end

    function automatic int rd_val(input int a);
        if (a == 0) return m_view ? m_wr : m_ivr;
        if (a == 1) return 'hD0;
        if (a == 7) return 'hFF;
        if (a == 8) return m_view * 128;
        return m_gp[a];
    endfunction

    function automatic int adv(input int a);
        return (a == 8) ? 0 : a + 1;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
        was_busy = (m_busy > 0);
        if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0 && m_pu == 1) begin m_pu = 0; m_wr = m_ivr; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin tick(); @(negedge clk); end
    endtask

    task automatic model_wbyte(input int d, output int ok);
        ok = 0;
        if (m_mode == 1) begin
            if (d <= 8 && d != 7) begin m_ptr = d; m_mode = 2; ok = 1; end
            else m_mode = 3;
            m_pend = 0;
        end else if (m_mode == 2) begin
            m_pend = 0;
            if (m_ptr == 8) begin
                m_view = d / 128; ok = (d % 128 == 0); m_ptr = 0;
            end else begin
                if (m_ptr == 1) ok = 1;
                else if (m_ptr == 0 && m_view == 1) begin m_wr = d; ok = 1; end
                else if (wp_n) begin
                    ok = 1; m_pend = 1; m_paddr = m_ptr; m_pdata = d;
                    if (m_ptr == 0) m_wr = d;
                end
                m_ptr = adv(m_ptr); m_mode = 3;
            end
        end else m_pend = 0;
    endtask

    task automatic send_byte(input int d, input string req);
        int ok; bit ign;
        evt_wbyte = 1; wbyte_data = 8'(d);
        tick(); evt_wbyte = 0;
        ign = was_busy; ok = 0;
        if (!ign) model_wbyte(d, ok);
        @(negedge clk);
        check({req, " ackvld"}, int'(ack_vld), int'(!ign));
        if (!ign) check({req, " ack"}, int'(ack_ok), ok);
    endtask

    task automatic get_byte(input string req);
        int exp; bit ign;
        evt_rbyte = 1;
        tick(); evt_rbyte = 0;
        ign = was_busy;
        exp = 0;
        if (!ign) begin exp = rd_val(m_ptr); m_ptr = adv(m_ptr); end
        @(negedge clk);
        check({req, " rdvld"}, int'(rd_vld), int'(!ign));
        if (!ign) check({req, " data"}, int'(rd_data), exp);
    endtask

    task automatic do_start(input bit rw);
        evt_start = 1; evt_rw = rw;
        tick(); evt_start = 0; evt_rw = 0;
        if (!was_busy) begin m_mode = rw ? 0 : 1; m_pend = 0; end
        @(negedge clk);
    endtask

    task automatic do_stop();
        evt_stop = 1;
        tick(); evt_stop = 0;
        if (!was_busy) begin
            if (m_pend && wp_n) begin
                if (m_paddr == 0) m_ivr = m_pdata; else m_gp[m_paddr] = m_pdata;
                m_busy = NV;
            end
            m_pend = 0; m_mode = 0;
        end
        @(negedge clk);
    endtask

    task automatic wr_reg(input int a, input int d, input string req);
        do_start(0); send_byte(a, req); send_byte(d, req); do_stop();
    endtask

    task automatic rd_reg(input int a, input string req);
        do_start(0); send_byte(a, req); do_start(1); get_byte(req); do_stop();
    endtask

    task automatic model_soft_reset();
        m_wr = 128; m_view = 0; m_ptr = 0; m_mode = 0; m_pend = 0;
        m_busy = PU + 1; m_pu = 1;
    endtask

    task automatic soft_reset();
        chk_en = 0; rst_n = 0;
        tick(); tick(); @(negedge clk);
        check("R1 reset ack", int'(ack_vld), 0);
        check("R1 reset busy", int'(busy), 1);
        check("R1 reset wiper", int'(wiper_pos), 'h80);
        rst_n = 1; model_soft_reset(); chk_en = 1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        m_ivr = 128;
        for (int i = 2; i <= 6; i++) m_gp[i] = 0;
        model_soft_reset();
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1; chk_en = 1;
        idle(PU + 4);                                   // R1 power-up window
        // R6 identification and R7 defaults, R12 sequential
        rd_reg(1, "R6");
        do_start(0); send_byte(1, "R6"); do_start(1);
        get_byte("R6 id"); get_byte("R7 gp2"); do_stop();
        // R3 volatile view, R4 write to wiper only, R5 immediate
        do_start(0); send_byte(8, "R3"); send_byte('h80, "R3");
        send_byte('h33, "R4"); do_stop();
        check("R4 nobusy", int'(busy), 0);
        rd_reg(0, "R4 vol read");
        // R3 illegal control values
        do_start(0); send_byte(8, "R9"); send_byte('h81, "R3");
        send_byte('h40, "R9 multi"); send_byte('h41, "R9 closed"); do_stop();
        do_start(0); send_byte(8, "R3"); send_byte('h01, "R3"); do_stop();
        rd_reg(8, "R3 read");
        // R13 tap extremes
        wr_reg(8, 'h80, "R3");
        wr_reg(0, 'h00, "R13");
        check("R13 low end", int'(tap_sel[0]), 1);
        wr_reg(0, 'hFF, "R13");
        check("R13 high end", int'(tap_sel[255]), 1);
        wr_reg(8, 'h00, "R3");
        // R4 non-volatile view, R5 before commit, R11 busy window
        do_start(0); send_byte(0, "R4"); send_byte('h5A, "R5");
        check("R5 wiper early", int'(wiper_pos), 'h5A);
        do_stop();
        do_start(0); send_byte(2, "R11 ignored"); get_byte("R11 ignored"); do_stop();
        idle(NV + 2);
        rd_reg(0, "R4 nv read");
        // R2 illegal addresses
        do_start(0); send_byte(7, "R2"); send_byte('h11, "R2 after"); do_stop();
        do_start(0); send_byte('h20, "R2"); do_stop();
        do_start(0); send_byte('h09, "R2"); do_stop();
        // R10 repeated start drops a staged write
        do_start(0); send_byte(4, "R10"); send_byte('hC3, "R10");
        do_start(0); do_stop();
        check("R10 nobusy", int'(busy), 0);
        rd_reg(4, "R10 read");
        // R9 extra byte after a non-volatile byte
        do_start(0); send_byte(4, "R9"); send_byte('hC3, "R9");
        send_byte('h11, "R9 extra"); do_stop();
        rd_reg(4, "R9 read");
        // R8 protect after commit start has no effect
        wr_reg(5, 'h77, "R7");
        wp_n = 0; idle(NV + 2); wp_n = 1;
        rd_reg(5, "R8 committed");
        // R8 protect at data byte, and at stop
        wp_n = 0;
        do_start(0); send_byte(3, "R8"); send_byte('h99, "R8 data"); do_stop();
        do_start(0); send_byte(0, "R8"); send_byte('h12, "R8 iv"); do_stop();
        wp_n = 1;
        do_start(0); send_byte(3, "R8"); send_byte('h99, "R8");
        wp_n = 0; do_stop(); wp_n = 1;
        check("R8 nobusy", int'(busy), 0);
        rd_reg(3, "R8 read");
        // R6 write to identification byte
        wr_reg(1, 'h55, "R6 write");
        rd_reg(1, "R6 read");
        // R12 sequential through hole, control and wrap; then no-address read
        do_start(0); send_byte(6, "R12"); do_start(1);
        get_byte("R12 a6"); get_byte("R12 hole"); get_byte("R12 ctrl");
        get_byte("R12 wrap"); do_stop();
        do_start(1); get_byte("R12 cont"); do_stop();
        // R7 soft reset keeps non-volatile contents, R1 reload
        wr_reg(8, 'h80, "R3");
        wr_reg(0, 'h21, "R4");
        soft_reset();
        idle(PU + 4);
        rd_reg(0, "R7 ivr kept");
        rd_reg(5, "R7 gp kept");
        rd_reg(8, "R3 reset");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule